// File: doc/BRIEF.md
# TDM Serial Frame Timing and Channel Capture

This block keeps the frame time base for eight serial time-division streams running at 2048 kbit/s each, clocked by a 4.096 MHz bit clock. An active-low frame pulse re-aligns the time base. Each frame lasts 125 µs and spans 512 clock periods. It carries 32 channels of 8 bits on every stream, so each bit cell is two clock periods wide and each channel is sixteen clock periods wide.

All eight input streams are deserialized in parallel, most significant bit first. Each completed byte is written into a 256-entry byte store at the address formed by the stream number above the channel number. The current channel, bit position and cell half are exported so that a separate output serializer can stay in step. A registered read port lets a processor-side block fetch any stored byte.

Top module: `tdm_capture_core`

## Requirements
- R1: A synchronous active-high `rst` sets the time base to the first clock of channel 0, bit 7, early half (`chan_idx`=0, `bit_idx`=7, `half_cell`=0, `frame_start`=1). It clears every byte of the store to 0 and clears `rd_data` to 0.
- R2: The time base advances by one position per clock. `half_cell` alternates 0,1 within each bit cell. `bit_idx` steps down from 7 to 0 every two clocks. `chan_idx` increments every 16 clocks, so one frame is 512 clocks.
- R3: With `frame_n` held high, the time base wraps freely from channel 31, bit 0, late half to channel 0, bit 7, early half.
- R4: `frame_n` sampled low at a clock edge forces the time base to position 0 on the next cycle, whatever its current position.
- R5: Each stream bit is sampled at the clock edge that ends the early half (`half_cell`=0) of its cell. The first sampled bit of a channel is its most significant bit.
- R6: The byte of every stream is written at the edge that ends the early half of the bit-0 cell. It is written to address {stream[2:0], channel[4:0]}, with all eight streams written on that same edge. No other location changes.
- R7: `rd_data` shows, one clock after `rd_addr` is presented, the store content held before any write on that same edge.
- R8: `frame_start` is 1 exactly in the cycles where the time base is at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame alignment pulse |
| ser_in | input | 8 | One serial input bit per stream |
| rd_addr | input | 8 | Store read address {stream, channel} |
| rd_data | output | 8 | Registered read data |
| chan_idx | output | 5 | Current channel number |
| bit_idx | output | 3 | Current bit position, 7 first |
| half_cell | output | 1 | 0 in the early half of a bit cell, 1 in the late half |
| frame_start | output | 1 | High at time-base position 0 |

## Verification
On every cycle, the assertions check the following:
- the one-step advance of the time base and its realignment after a low frame pulse;
- that `frame_start` follows either a wrap or a pulse;
- that sampling happens only in early halves;
- that a store write occurs only once per channel, on the bit-0 sample.

Several properties need the bench's scenarios and its reference model, compared every clock:
- that the right bits land at the right {stream, channel} address;
- that a mid-frame pulse leaves earlier bytes intact;
- that a read issued in the same cycle as a write returns the old byte;
- that reset clears the store.

// File: rtl/tdmc_pkg.sv
package tdmc_pkg;

    localparam int STREAMS_DEF = 8;
    localparam int CHANS_DEF   = 32;
    localparam int BYTE_W_DEF  = 8;

    typedef enum logic {
        HALF_EARLY = 1'b0,
        HALF_LATE  = 1'b1
    } cell_half_e;

    // Store address: stream number above channel number.
    function automatic logic [7:0] slot_addr(input logic [2:0] stream, input logic [4:0] chan);
        return {stream, chan};
    endfunction

endpackage

// File: rtl/tdmc_frame_timer.sv
module tdmc_frame_timer #(
    parameter int CH_W  = 5,
    parameter int BIT_W = 3,
    localparam int CNT_W = CH_W + BIT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    output logic [CH_W-1:0]  chan,
    output logic [BIT_W-1:0] bitpos,
    output logic             half,
    output logic             sample_en,
    output logic             last_sample,
    output logic             at_zero
);
    import tdmc_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    cell_half_e       half_e;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!frame_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        half_e      = cell_half_e'(cnt_q[0]);
        chan        = cnt_q[CNT_W-1 -: CH_W];
        bitpos      = ~cnt_q[BIT_W:1];
        half        = cnt_q[0];
        sample_en   = (half_e == HALF_EARLY);
        last_sample = sample_en && (cnt_q[BIT_W:1] == {BIT_W{1'b1}});
        at_zero     = (cnt_q == '0);
    end

endmodule

// File: rtl/tdmc_lane_deser.sv
module tdmc_lane_deser #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_en,
    input  logic              din,
    output logic [BYTE_W-1:0] byte_now
);
    logic [BYTE_W-1:0] sh_q;

    assign byte_now = {sh_q[BYTE_W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (sample_en) begin
            sh_q <= byte_now;
        end
    end

endmodule

// File: rtl/tdmc_chan_bank.sv
module tdmc_chan_bank #(
    parameter int N_CHANS = 32,
    parameter int BYTE_W  = 8,
    localparam int CH_W   = $clog2(N_CHANS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CH_W-1:0]   waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CH_W-1:0]   raddr,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] mem_q [N_CHANS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CHANS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/tdm_capture_core.sv
module tdm_capture_core #(
    parameter int N_STREAMS = tdmc_pkg::STREAMS_DEF,
    parameter int N_CHANS   = tdmc_pkg::CHANS_DEF,
    parameter int BYTE_W    = tdmc_pkg::BYTE_W_DEF,
    localparam int ST_W     = $clog2(N_STREAMS),
    localparam int CH_W     = $clog2(N_CHANS),
    localparam int BIT_W    = $clog2(BYTE_W),
    localparam int AW       = ST_W + CH_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_n,
    input  logic [N_STREAMS-1:0] ser_in,
    input  logic [AW-1:0]        rd_addr,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [CH_W-1:0]      chan_idx,
    output logic [BIT_W-1:0]     bit_idx,
    output logic                 half_cell,
    output logic                 frame_start
);
    logic cap_shift_en;
    logic cap_wr_en;

    logic [BYTE_W-1:0] lane_byte [N_STREAMS];
    logic [BYTE_W-1:0] bank_rd   [N_STREAMS];
    logic [BYTE_W-1:0] rd_data_q;

    tdmc_frame_timer #(.CH_W(CH_W), .BIT_W(BIT_W)) timer_i (
        .clk         (clk),
        .rst         (rst),
        .frame_n     (frame_n),
        .chan        (chan_idx),
        .bitpos      (bit_idx),
        .half        (half_cell),
        .sample_en   (cap_shift_en),
        .last_sample (cap_wr_en),
        .at_zero     (frame_start)
    );

    for (genvar s = 0; s < N_STREAMS; s++) begin : g_lane
        tdmc_lane_deser #(.BYTE_W(BYTE_W)) deser_i (
            .clk       (clk),
            .rst       (rst),
            .sample_en (cap_shift_en),
            .din       (ser_in[s]),
            .byte_now  (lane_byte[s])
        );

        tdmc_chan_bank #(.N_CHANS(N_CHANS), .BYTE_W(BYTE_W)) bank_i (
            .clk   (clk),
            .rst   (rst),
            .we    (cap_wr_en),
            .waddr (chan_idx),
            .wdata (lane_byte[s]),
            .raddr (rd_addr[CH_W-1:0]),
            .rdata (bank_rd[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q <= '0;
        end else begin
            rd_data_q <= bank_rd[rd_addr[AW-1 -: ST_W]];
        end
    end

    assign rd_data = rd_data_q;

endmodule

// File: rtl/tdmc_capture_chk.sv
module tdmc_capture_chk #(
    parameter int CH_W  = 5,
    parameter int BIT_W = 3,
    localparam int CNT_W = CH_W + BIT_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_n,
    input logic [CH_W-1:0]  chan_idx,
    input logic [BIT_W-1:0] bit_idx,
    input logic             half_cell,
    input logic             frame_start,
    input logic             cap_shift_en,
    input logic             cap_wr_en
);
    logic [CNT_W-1:0] pos;
    logic             armed_q;

    assign pos = {chan_idx, ~bit_idx, half_cell};

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        frame_n |=> pos == CNT_W'($past(pos) + 1'b1));

    // R4
    resync_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> pos == '0);

    // R8
    frame_start_src_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_q && frame_start) |-> ($past(!frame_n) || $past(pos) == {CNT_W{1'b1}}));

    // R5
    shift_phase_chk: assert property (@(posedge clk) disable iff (rst)
        cap_shift_en |-> !half_cell);

    // R6
    write_slot_chk: assert property (@(posedge clk) disable iff (rst)
        cap_wr_en |-> (cap_shift_en && bit_idx == '0));

    // R6
    write_once_chk: assert property (@(posedge clk) disable iff (rst)
        cap_wr_en |=> !cap_wr_en);

endmodule

bind tdm_capture_core tdmc_capture_chk #(.CH_W(CH_W), .BIT_W(BIT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .frame_n      (frame_n),
    .chan_idx     (chan_idx),
    .bit_idx      (bit_idx),
    .half_cell    (half_cell),
    .frame_start  (frame_start),
    .cap_shift_en (cap_shift_en),
    .cap_wr_en    (cap_wr_en)
);

// File: tb/tdm_capture_core_tb_top.sv
module tdm_capture_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_n = 1'b1;
    logic [7:0] ser_in = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [4:0] chan_idx;
    logic [2:0] bit_idx;
    logic       half_cell;
    logic       frame_start;

    always #2 clk = ~clk;

    tdm_capture_core dut_i (
        .clk         (clk),
        .rst         (rst),
        .frame_n     (frame_n),
        .ser_in      (ser_in),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .chan_idx    (chan_idx),
        .bit_idx     (bit_idx),
        .half_cell   (half_cell),
        .frame_start (frame_start)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // scenario controls
    int  seed       = 1;
    bit  auto_pulse = 1;
    int  force_at   = -1;
    int  rd_next    = 0;

    // behavioural reference
    int         m_cnt = 0;
    logic [7:0] m_sh  [8];
    logic [7:0] m_mem [256];
    logic [7:0] m_rd  = '0;

    function automatic logic [7:0] pat(int s, int ch, int sd);
        return 8'((s * 37 + ch * 11 + sd * 29) & 255);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            m_rd  = '0;
            for (int i = 0; i < 256; i++) m_mem[i] = '0;
            for (int s = 0; s < 8; s++) m_sh[s] = '0;
        end else begin
            m_rd = m_mem[rd_addr];
            if (m_cnt % 2 == 0) begin
                for (int s = 0; s < 8; s++) begin
                    m_sh[s] = {m_sh[s][6:0], ser_in[s]};
                    if ((m_cnt / 2) % 8 == 7) m_mem[s * 32 + m_cnt / 16] = m_sh[s];
                end
            end
            m_cnt = (frame_n == 1'b0) ? 0 : (m_cnt + 1) % 512;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // compare at negedge, then drive the next inputs
    task automatic tick();
        @(negedge clk);
        chk("R2 chan_idx", chan_idx, m_cnt / 16);
        chk("R2 bit_idx", bit_idx, 7 - (m_cnt / 2) % 8);
        chk("R2 half_cell", half_cell, m_cnt % 2);
        chk("R8 frame_start", frame_start, (m_cnt == 0) ? 1 : 0);
        chk("R7 rd_data vs model", rd_data, m_rd);
        frame_n = ((auto_pulse && m_cnt == 511) || (force_at == m_cnt)) ? 1'b0 : 1'b1;
        for (int s = 0; s < 8; s++) begin
            logic [7:0] b;
            b = pat(s, m_cnt / 16, seed);
            ser_in[s] = b[7 - (m_cnt / 2) % 8];
        end
        rd_addr = 8'(rd_next);
    endtask

    task automatic wait_cnt(int target);
        do tick(); while (m_cnt != target);
    endtask

    task automatic sweep_store(string req, int sd, bit expect_zero);
        for (int a = 0; a <= 256; a++) begin
            rd_next = a % 256;
            tick();
            if (a > 0) chk(req, rd_data, expect_zero ? 0 : pat((a - 1) / 32, (a - 1) % 32, sd));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // reset state
        tick();
        tick();
        chk("R1 reset chan", chan_idx, 0);
        chk("R1 reset bit", bit_idx, 7);
        chk("R1 reset half", half_cell, 0);
        chk("R1 reset frame_start", frame_start, 1);
        chk("R1 reset rd_data", rd_data, 0);
        rst = 1'b0;

        // two aligned frames with seed 1, then read every location (R5, R6)
        seed = 1;
        repeat (1100) tick();
        sweep_store("R6 store seed1", 1, 0);

        // new pattern: partial frame shows new and untouched channels (R6)
        seed = 7;
        wait_cnt(511);
        wait_cnt(81);
        rd_next = 5;
        tick();
        rd_next = 4;
        tick();
        chk("R6 ch5 untouched yet", rd_data, pat(0, 5, 1));
        tick();
        chk("R6 ch4 new byte", rd_data, pat(0, 4, 7));
        repeat (600) tick();
        sweep_store("R5 MSB-first seed7", 7, 0);

        // free-running wrap with no frame pulse (R3)
        auto_pulse = 0;
        wait_cnt(511);
        tick();
        chk("R3 wrap chan", chan_idx, 0);
        chk("R3 wrap bit", bit_idx, 7);
        chk("R3 wrap half", half_cell, 0);
        repeat (700) tick();

        // mid-frame realignment (R4)
        force_at = 100;
        wait_cnt(100);
        force_at = -1;
        tick();
        chk("R4 resync chan", chan_idx, 0);
        chk("R4 resync bit", bit_idx, 7);
        chk("R4 resync half", half_cell, 0);
        auto_pulse = 1;
        repeat (600) tick();
        sweep_store("R4 store after resync", 7, 0);

        // reset mid-run clears store (R1)
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        rd_next = 8'hA5;
        tick();
        rd_next = 8'h13;
        tick();
        chk("R1 cleared A5", rd_data, 0);
        tick();
        chk("R1 cleared 13", rd_data, 0);
        repeat (20) tick();

        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule